// File: doc/BRIEF.md
# Page Transfer Sequencer with Interleaved ECC Fetch

This block walks one flash page between a word-wide memory port and the flash data FIFO. Each 256-byte chunk of page data moves as 64 words, grouped into bursts. After every chunk the sequencer issues one extra beat that copies the ECC result word into a numbered ECC buffer slot. Once all chunks are done, it moves the spare area. A transfer shorter than one chunk is a spare-only transfer: a single element, with no ECC beat.

Every word movement is presented as one beat on a valid/ready stream. A beat carries a kind, a memory word address (for ECC beats, the slot number), a direction flag and a terminal-count flag. Once `mv_valid` is high, the beat and all of its fields stay unchanged until `mv_ready` is sampled high. The consumer may hold `mv_ready` low for any number of cycles.

A small configuration register selects the direction and the burst mode. A byte counter tracks how much of the transfer remains. When the final beat is accepted, the sequencer clears its own configuration bits.

Top module: `page_ecc_dma_seq`

## Requirements
- R1: After reset, `run`, `cfg_q`, `xfer_cnt` and `mv_valid` are all 0.
- R2: While `run` is 0, `cfg_we` loads `cfg_wdata` into `cfg_q` on the next cycle. While `run` is 1, `cfg_we` is ignored. The bits of `cfg_q` mean:
  - bit 1: 1 = read (FIFO to memory), 0 = write.
  - bit 2: 1 = burst mode.
  - bits 3 and 4: ECC enables.
  - bit 0: spare; it is stored and left alone.
- R3: A `go` pulse is accepted only when all three hold: `run` is 0, `go_len` is at least 4, and `go_len` is at most 2048. When accepted, `run` is 1 on the next cycle. Any other `go` is ignored.
- R4: The beat order depends on `go_len`.
  - If `go_len` ≥ 256: for each chunk n, from 0 to `go_len`/256 - 1, there are 64 data beats (kind 0), then one ECC beat (kind 1, address n). After the last chunk comes a spare element of (`go_len`/32)/4 beats (kind 2).
  - If `go_len` < 256: a single spare element of `go_len`/4 beats.
- R5: Data and spare beats carry consecutive word addresses, starting at `go_base` and continuing across the whole transfer. `mv_to_mem` equals `cfg_q` bit 1 as latched at `go` for data and spare beats, and is 1 for ECC beats.
- R6: A data or spare burst starts only after a cycle in which the FIFO can supply or absorb B words.
  - B is 4 in burst mode and 1 otherwise.
  - In read mode, the condition is `fifo_level` ≥ B. In write mode, it is 16 - `fifo_level` ≥ B.
  - A burst carries at most B beats.
- R7: While `mv_valid` is high and `mv_ready` is low, `mv_valid` stays high and `mv_kind`, `mv_addr`, `mv_to_mem` and `mv_last` hold their values.
- R8: `mv_last` is high only on the final beat of the transfer.
- R9: When `go` is accepted, the count loads only if `fifo_level` is 0 and `xfer_cnt` is 0. It loads `go_len` + `go_len`/32, or just `go_len` for a spare-only transfer. Otherwise the count is left unchanged.
- R10: Each accepted data or spare beat lowers `xfer_cnt` by 4, stopping at 0. ECC beats leave it unchanged.
- R11: On the cycle after the final beat is accepted, `run` is 0 and `cfg_q` bits 1 to 4 are 0. Bit 0 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration value |
| cfg_q | output | 5 | Configuration register |
| go | input | 1 | Start pulse |
| go_len | input | 12 | Transfer length in bytes |
| go_base | input | 16 | First memory word address |
| run | output | 1 | Transfer in progress |
| fifo_level | input | 5 | Words currently held in the flash data FIFO |
| xfer_cnt | output | 12 | Remaining byte count |
| mv_valid | output | 1 | Beat valid |
| mv_ready | input | 1 | Beat accepted |
| mv_kind | output | 2 | 0 data, 1 ECC, 2 spare |
| mv_addr | output | 16 | Memory word address, or ECC slot |
| mv_to_mem | output | 1 | Beat moves toward memory |
| mv_last | output | 1 | Terminal-count beat |

## Verification
The hardest case to reach is a burst start that is held off for many cycles. This happens while the FIFO level sits just under the threshold, and the back-pressure of the beat stream has to overlap it. The stimulus drives `fifo_level` and `mv_ready` from a pseudo-random source on every cycle, in both directions and both burst modes. It then checks the FIFO condition of the previous cycle at every burst start.

The count-load skip is reached by holding `fifo_level` non-zero in the cycle of an accepted `go`. A second `go` and a configuration write are issued in the middle of a running page, to show that both are ignored.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  typedef enum logic [1:0] {K_DATA = 2'd0, K_ECC = 2'd1, K_SPARE = 2'd2} beat_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BEAT, S_ECC} seq_state_e;
endpackage

// File: rtl/pgseq_gate.sv
module pgseq_gate #(
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  localparam int LVW = $clog2(DEPTH + 1)
) (
  input  logic [LVW-1:0] level,
  input  logic           to_mem,
  input  logic           burst_mode,
  output logic           ok
);
  logic [LVW-1:0] need;
  logic [LVW-1:0] room;

  always_comb begin
    need = burst_mode ? LVW'(BURST) : LVW'(1);
    room = LVW'(DEPTH) - level;
    ok   = to_mem ? (level >= need) : (room >= need);
  end
endmodule

// File: rtl/pgseq_tcount.sv
module pgseq_tcount #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [LW-1:0] load_val,
  input  logic          fifo_empty,
  input  logic          dec,
  output logic [LW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load_req && fifo_empty && cnt == '0) cnt <= load_val;
    else if (dec) cnt <= (cnt >= LW'(4)) ? cnt - LW'(4) : '0;
  end

  // R10: without a load the count never rises
  a_r10_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> cnt <= $past(cnt));
  // R9: a load request is refused while data is pending or the count is busy
  a_r9_load_guard: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && (cnt != '0 || !fifo_empty) |=> cnt <= $past(cnt));
endmodule

// File: rtl/page_ecc_dma_seq.sv
module page_ecc_dma_seq
  import pgseq_pkg::*;
#(
  parameter int AW          = 16,
  parameter int LW          = 12,
  parameter int CHUNK_BYTES = 256,
  parameter int BURST       = 4,
  parameter int ECC_SLOTS   = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int SPARE_DIV   = 32,
  localparam int LVW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [4:0]     cfg_wdata,
  output logic [4:0]     cfg_q,
  input  logic           go,
  input  logic [LW-1:0]  go_len,
  input  logic [AW-1:0]  go_base,
  output logic           run,
  input  logic [LVW-1:0] fifo_level,
  output logic [LW-1:0]  xfer_cnt,
  output logic           mv_valid,
  input  logic           mv_ready,
  output logic [1:0]     mv_kind,
  output logic [AW-1:0]  mv_addr,
  output logic           mv_to_mem,
  output logic           mv_last
);
  localparam int CHUNK_WORDS = CHUNK_BYTES / 4;
  localparam int MAX_BYTES   = ECC_SLOTS * CHUNK_BYTES;
  localparam int CW          = $clog2(ECC_SLOTS + 1);
  localparam int BW          = $clog2(BURST + 1);

  seq_state_e     st;
  beat_kind_e     kind;
  logic           dir_rd, bmode;
  logic [AW-1:0]  waddr;
  logic [CW-1:0]  chunk, nchunks;
  logic [LW-1:0]  elem_left, spare_words;
  logic [BW-1:0]  beats_left;
  logic           go_ok, gate_ok, fin, nch_zero;
  logic [LW-1:0]  nch_full, load_val;

  always_comb begin
    go_ok     = go && !run && go_len >= LW'(4) && go_len <= LW'(MAX_BYTES);
    nch_full  = go_len / LW'(CHUNK_BYTES);
    nch_zero  = (nch_full == '0);
    load_val  = nch_zero ? go_len : go_len + go_len / LW'(SPARE_DIV);
    run       = (st != S_IDLE);
    mv_valid  = (st == S_BEAT) || (st == S_ECC);
    mv_kind   = (st == S_ECC) ? K_ECC : kind;
    mv_addr   = (st == S_ECC) ? AW'(chunk) : waddr;
    mv_to_mem = (st == S_ECC) ? 1'b1 : dir_rd;
    mv_last   = (st == S_BEAT) && (kind == K_SPARE) && (elem_left == LW'(1));
    fin       = mv_last && mv_ready;
  end

  pgseq_gate #(.DEPTH(FIFO_DEPTH), .BURST(BURST)) u_gate (
    .level(fifo_level), .to_mem(dir_rd), .burst_mode(bmode), .ok(gate_ok)
  );

  pgseq_tcount #(.LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_req(go_ok), .load_val(load_val),
    .fifo_empty(fifo_level == '0),
    .dec((st == S_BEAT) && mv_ready),
    .cnt(xfer_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we && !run) cfg_q <= cfg_wdata;
    else if (fin) cfg_q[4:1] <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_DATA; dir_rd <= 1'b0; bmode <= 1'b0;
      waddr <= '0; chunk <= '0; nchunks <= '0; elem_left <= '0;
      spare_words <= '0; beats_left <= '0;
    end else begin
      case (st)
        S_IDLE: if (go_ok) begin
          st          <= S_WAIT;
          dir_rd      <= cfg_q[1];
          bmode       <= cfg_q[2];
          waddr       <= go_base;
          chunk       <= '0;
          nchunks     <= CW'(nch_full);
          spare_words <= (go_len / LW'(SPARE_DIV)) >> 2;
          kind        <= nch_zero ? K_SPARE : K_DATA;
          elem_left   <= nch_zero ? (go_len >> 2) : LW'(CHUNK_WORDS);
        end
        S_WAIT: if (gate_ok) begin
          st         <= S_BEAT;
          beats_left <= bmode ? BW'(BURST) : BW'(1);
        end
        S_BEAT: if (mv_ready) begin
          waddr      <= waddr + AW'(1);
          elem_left  <= elem_left - LW'(1);
          beats_left <= beats_left - BW'(1);
          if (elem_left == LW'(1)) st <= (kind == K_DATA) ? S_ECC : S_IDLE;
          else if (beats_left == BW'(1)) st <= S_WAIT;
        end
        S_ECC: if (mv_ready) begin
          chunk <= chunk + CW'(1);
          st    <= S_WAIT;
          if (chunk + CW'(1) == nchunks) begin
            kind      <= K_SPARE;
            elem_left <= spare_words;
          end else begin
            kind      <= K_DATA;
            elem_left <= LW'(CHUNK_WORDS);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6: every data or spare burst opens after a cycle with enough FIFO words or room
  a_r6_burst_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mv_valid) && mv_kind != K_ECC |-> $past(gate_ok));
  // R7: an offered beat is held unchanged until accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_addr) && $stable(mv_kind)
      && $stable(mv_to_mem) && $stable(mv_last));
  // R8: the terminal-count beat ends the transfer
  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mv_last && mv_ready |=> !run);
  // R11: configuration bits 1..4 are clear when the transfer stops
  a_r11_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> cfg_q[4:1] == 4'b0);
  // R4: ECC beats address an existing slot
  a_r4_ecc_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && mv_kind == K_ECC |-> mv_addr < AW'(ECC_SLOTS));
endmodule

// File: tb/page_ecc_dma_seq_tb.sv
module page_ecc_dma_seq_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0, cfg_q;
  logic        go = 1'b0;
  logic [11:0] go_len = '0;
  logic [15:0] go_base = '0;
  logic        run;
  logic [4:0]  fifo_level = '0;
  logic [11:0] xfer_cnt;
  logic        mv_valid, mv_ready = 1'b0, mv_to_mem, mv_last;
  logic [1:0]  mv_kind;
  logic [15:0] mv_addr;

  page_ecc_dma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .go(go), .go_len(go_len), .go_base(go_base), .run(run), .fifo_level(fifo_level),
    .xfer_cnt(xfer_cnt), .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_kind(mv_kind),
    .mv_addr(mv_addr), .mv_to_mem(mv_to_mem), .mv_last(mv_last)
  );

  always #(PERIOD / 2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit wd_fired = 1'b0, hold_lvl = 1'b0;
  int unsigned rs = 32'h1234_5678;

  // reference model state
  logic [19:0] exp_q[$];
  bit          m_run = 1'b0, m_dir = 1'b0;
  logic [4:0]  m_cfg = '0;
  int          m_cnt = 0, m_b = 1, seg = 0;
  int          prev_lvl = 0;
  bit          prev_v = 1'b0, prev_stall = 1'b0;
  logic [1:0]  prev_k = '0;
  logic [19:0] prev_beat = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pk(bit last, bit tm, int kind, int addr);
    return {last, tm, 2'(kind), 16'(addr)};
  endfunction

  task automatic build(int len, int base, bit dir);
    int a = base;
    int nch = len / 256;
    if (nch == 0) begin
      for (int j = 0; j < len / 4; j++) exp_q.push_back(pk(j == len / 4 - 1, dir, 2, base + j));
    end else begin
      int sw = (len / 32) / 4;
      for (int n = 0; n < nch; n++) begin
        for (int k = 0; k < 64; k++) begin exp_q.push_back(pk(0, dir, 0, a)); a++; end
        exp_q.push_back(pk(0, 1, 1, n));
      end
      for (int j = 0; j < sw; j++) begin exp_q.push_back(pk(j == sw - 1, dir, 2, a)); a++; end
    end
  endtask

  function automatic bit gate(int lvl, bit dir, int b);
    return dir ? (lvl >= b) : (16 - lvl >= b);
  endfunction

  // pseudo-random FIFO level and back-pressure, driven after the edge
  always @(posedge clk) begin
    #2;
    rs = rs * 32'd1103515245 + 32'd12345;
    if (!hold_lvl) fifo_level = 5'((rs >> 16) % 17);
    mv_ready = rs[27] | rs[29];
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    logic [19:0] cur, e;
    bit old_run, hs;
    if (!rst_n) begin
      chk(run == 1'b0 && cfg_q == '0 && xfer_cnt == '0 && mv_valid == 1'b0,
          "R1 reset state", {run, mv_valid, cfg_q, xfer_cnt}, 0);
    end else begin
      cycles++;
      if (cycles > 150000 && !wd_fired) begin
        wd_fired = 1'b1; n_bad++;
        $display("FAIL R3 watchdog: run actual=%0d expected=0", run);
      end
      chk(run == m_run, "R3/R11 run", run, m_run);
      chk(cfg_q == m_cfg, "R2/R11 cfg_q", cfg_q, m_cfg);
      chk(xfer_cnt == 12'(m_cnt), "R9/R10 xfer_cnt", xfer_cnt, m_cnt);
      cur = {mv_last, mv_to_mem, mv_kind, mv_addr};
      if (prev_stall) chk(mv_valid && cur == prev_beat, "R7 beat held", cur, prev_beat);
      if (mv_valid && (!prev_v || mv_kind != prev_k)) seg = 0;
      if (mv_valid && !prev_v && mv_kind != 2'd1)
        chk(gate(prev_lvl, m_dir, m_b), "R6 burst start gate", prev_lvl, m_b);
      old_run = m_run;
      hs = mv_valid && mv_ready;
      if (hs) begin
        if (mv_kind != 2'd1) begin
          seg++;
          chk(seg <= m_b, "R6 burst length", seg, m_b);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected beat", cur, 0);
        end else begin
          e = exp_q.pop_front();
          chk(mv_kind == e[17:16], "R4 beat kind", mv_kind, e[17:16]);
          chk(mv_addr == e[15:0] && mv_to_mem == e[18], "R5 address/direction", {mv_to_mem, mv_addr}, e[18:0]);
          chk(mv_last == e[19], "R8 terminal flag", mv_last, e[19]);
          if (e[19]) begin m_run = 1'b0; m_cfg = m_cfg & 5'b00001; end
        end
        if (mv_kind != 2'd1) m_cnt = (m_cnt >= 4) ? m_cnt - 4 : 0;
      end
      if (go && !old_run && go_len >= 4 && go_len <= 2048) begin
        m_run = 1'b1; m_dir = m_cfg[1]; m_b = m_cfg[2] ? 4 : 1;
        if (fifo_level == 0 && m_cnt == 0)
          m_cnt = (go_len < 256) ? int'(go_len) : int'(go_len) + int'(go_len) / 32;
        build(int'(go_len), int'(go_base), m_cfg[1]);
      end
      if (cfg_we && !old_run) m_cfg = cfg_wdata;
      prev_lvl = fifo_level; prev_v = mv_valid; prev_k = mv_kind;
      prev_stall = mv_valid && !mv_ready; prev_beat = cur;
    end
  end

  task automatic wr_cfg(input logic [4:0] v);
    @(posedge clk); #1; cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1; cfg_we = 1'b0;
  endtask

  task automatic start(input int len, input int base, input int lvl);
    @(posedge clk); #1; go = 1'b1; go_len = 12'(len); go_base = 16'(base);
    hold_lvl = 1'b1; fifo_level = 5'(lvl);
    @(posedge clk); #1; go = 1'b0; hold_lvl = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    while ((run || exp_q.size() != 0) && !wd_fired) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1; rst_n = 1'b1;
    // R2 R4 R9: read page of 512 bytes in burst mode, count loads 528
    wr_cfg(5'b00110);
    start(512, 'h100, 0);
    wait_idle("R4 read 512 complete");
    // R11: write page of 2048, single-word bursts, ECC bits and spare bit 0 set
    wr_cfg(5'b11001);
    start(2048, 'h2000, 0);
    wait_idle("R4 write 2048 complete");
    // R4 R9: spare-only read of 16 bytes
    wr_cfg(5'b00110);
    start(16, 'h40, 0);
    wait_idle("R4 spare-only complete");
    // R9: FIFO not empty at go, so count is not loaded
    wr_cfg(5'b00100);
    start(512, 'h0, 3);
    wait_idle("R9 skip-load transfer complete");
    // R2 R3: go and configuration write while busy are ignored
    wr_cfg(5'b00110);
    start(256, 'h500, 0);
    repeat (20) @(posedge clk);
    start(16, 'h900, 0);
    wr_cfg(5'b01111);
    wait_idle("R3 busy go ignored");
    // R3: too short and too long lengths are ignored
    start(2, 'h10, 0);
    repeat (4) @(negedge clk);
    start(3000, 'h10, 0);
    repeat (4) @(negedge clk);
    chk(run == 1'b0, "R3 out-of-range go ignored", run, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule